// File: doc/BRIEF.md
# I2C Master Byte Receiver with Optional Wait Stretch

This block is the receive half of an I2C master. Once the bus has been claimed (the start condition and the address phase are handled elsewhere), the host pulls bytes off the bus through a small register-style interface. That interface has two parts:

- a receive data register;
- a 5-bit control word holding the interrupt flag, the acknowledge-select bit, the wait-mode bit, the direction bit and the bus-busy bit.

The engine produces SCL from a divided system clock, shifts eight data bits in from SDA, and drives the ninth (acknowledge) bit. Both pads are open-drain, so each is modelled as an active-high pull-low enable plus, for SDA, an input level.

A read of the data register starts the next byte. A "dummy" read starts the first one. In wait mode the engine raises the flag as soon as the eighth clock falls and parks SCL low, so the host can pick the acknowledge level before the ninth clock. Clearing the flag lets the ninth clock go ahead. Without wait mode the flag rises with the ninth clock.

To finish a transfer, the host sets the direction bit to transmit and then writes bus-busy to 0. The engine then ends the bus with a stop condition once the current byte has completed.

Top module: `i2c_rx_master`

## Requirements
- R1: After reset the control word reads 0, the data register reads 0, and neither SCL nor SDA is pulled low.
- R2: Writing control bit 4 (bus-busy) = 1 while the bus is free claims it, and SCL is then held low. While busy with bit 3 (direction) = 0, a data-register read starts a byte, and the first SCL rise is seen HALF+2 cycles after the read strobe. A read while the bus is free has no effect.
- R3: Data bits are sampled from SDA at the middle of each SCL high phase, most significant bit first. The completed byte is in the data register by the time the flag (control bit 0) rises.
- R4: With control bit 2 (wait) = 1, the flag rises at the end of the eighth SCL high phase, and SCL stays low for as long as the flag is 1. No second flag is raised at the ninth rise.
- R5: Clearing the flag during a wait releases the ninth SCL rise HALF+2 cycles after the clearing write.
- R6: With wait = 0, the flag rises together with the ninth SCL rise.
- R7: During the ninth bit, SDA is pulled low when control bit 1 (ack-select) is 0 and released when it is 1. The level is taken when the ninth low phase begins and does not change while SCL is high.
- R8: A data read made after a byte has completed, or while it is still running, starts the next byte. A read after a stop request has no effect.
- R9: With direction = 1, writing bus-busy = 0 requests a stop. After the current byte, the engine pulls SDA low with SCL low, releases SCL, then releases SDA, makes exactly one SCL rise, and only then reads busy = 0.
- R10: Writing bus-busy = 0 while direction = 0 is ignored: the bus stays claimed and SCL stays low.
- R11: A control write with bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves it unchanged.
- R12: Each SCL high phase lasts HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control write data {busy, dir, wait, ack_sel, flag} |
| ctl_rdata | output | 5 | Control word readback, same layout |
| dat_rd | input | 1 | Data register read strobe |
| rx_data | output | 8 | Last received byte |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
Each timed result has a fixed latency:

- A read strobe or a flag-clearing write lands in a register one edge later.
- The state machine acts on it at the next edge.
- The SCL low phase then runs for HALF cycles.

So the first SCL rise is due HALF+2 falling clock edges after the stimulus was driven. The bench drives on falling edges and counts falling edges up to that rise. The flag is polled each cycle, and the SCL, SDA and data outputs are checked in the very cycle it first reads 1. The stop sequence is followed one cycle at a time from the end of the ninth clock until busy clears.

// File: rtl/i2c_rx_master.sv
module i2c_rx_master #(
  parameter int HALF = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [4:0] ctl_wdata,
  output logic [4:0] ctl_rdata,
  input  logic       dat_rd,
  output logic [7:0] rx_data,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int CW   = $clog2(HALF + 1);
  localparam int MID  = HALF / 2;
  localparam int LAST = HALF - 1;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_WAIT, S_STOP1, S_STOP2, S_STOP3} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [3:0]  bitc;
  logic [7:0]  shreg;
  logic        irq, ack_sel, wait_en, dir_tx, busy;
  logic        rd_pend, stop_pend, ack_drv;

  wire phase_end = (cnt == CW'(LAST));
  wire counting  = (st == S_LOW) || (st == S_HIGH) || (st == S_STOP1) ||
                   (st == S_STOP2) || (st == S_STOP3);
  wire clr_flag  = ctl_wr && !ctl_wdata[0];
  wire stop_req  = ctl_wr && !ctl_wdata[4] && busy && dir_tx && !stop_pend;
  wire claim     = ctl_wr && ctl_wdata[4] && !busy;
  wire start_ok  = (st == S_IDLE) && !stop_pend && rd_pend && busy && !dir_tx;
  wire set_wait  = (st == S_HIGH) && phase_end && (bitc == 4'd7) && wait_en;
  wire set_nine  = (st == S_LOW) && phase_end && (bitc == 4'd8) && !wait_en;
  wire stop_done = (st == S_STOP3) && phase_end;

  assign ctl_rdata = {busy, dir_tx, wait_en, ack_sel, irq};

  always_comb begin
    case (st)
      S_IDLE:                   scl_oe = busy;
      S_LOW, S_WAIT, S_STOP1:   scl_oe = 1'b1;
      default:                  scl_oe = 1'b0;
    endcase
  end

  always_comb begin
    case (st)
      S_LOW, S_HIGH:    sda_oe = (bitc == 4'd8) && ack_drv;
      S_STOP1, S_STOP2: sda_oe = 1'b1;
      default:          sda_oe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sel <= 1'b0;
      wait_en <= 1'b0;
      dir_tx  <= 1'b0;
    end else if (ctl_wr) begin
      ack_sel <= ctl_wdata[1];
      wait_en <= ctl_wdata[2];
      dir_tx  <= ctl_wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   irq <= 1'b0;
    else if (set_wait || set_nine) irq <= 1'b1;
    else if (clr_flag)             irq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      stop_pend <= 1'b0;
    end else begin
      if (claim)     busy <= 1'b1;
      if (stop_req)  stop_pend <= 1'b1;
      if (stop_done) begin
        busy      <= 1'b0;
        stop_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      rd_pend <= 1'b0;
    else if (stop_req || stop_pend)                  rd_pend <= 1'b0;
    else if (dat_rd && busy)                         rd_pend <= 1'b1;
    else if (start_ok)                               rd_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!counting || phase_end) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bitc    <= '0;
      shreg   <= '0;
      rx_data <= '0;
      ack_drv <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (stop_pend) st <= S_STOP1;
          else if (start_ok) begin
            st   <= S_LOW;
            bitc <= '0;
          end
        end
        S_LOW: if (phase_end) st <= S_HIGH;
        S_HIGH: begin
          if (cnt == CW'(MID) && bitc < 4'd8) shreg <= {shreg[6:0], sda_in};
          if (phase_end) begin
            if (bitc == 4'd7) begin
              rx_data <= shreg;
              bitc    <= 4'd8;
              if (wait_en) st <= S_WAIT;
              else begin
                st      <= S_LOW;
                ack_drv <= !ack_sel;
              end
            end else if (bitc == 4'd8) begin
              st <= S_IDLE;
            end else begin
              bitc <= bitc + 4'd1;
              st   <= S_LOW;
            end
          end
        end
        S_WAIT: if (!irq) begin
          st      <= S_LOW;
          ack_drv <= !ack_sel;
        end
        S_STOP1: if (phase_end) st <= S_STOP2;
        S_STOP2: if (phase_end) st <= S_STOP3;
        S_STOP3: if (phase_end) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_FREE_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe)); // R1
  AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && irq) |=> scl_oe); // R4
  AST_FLAG_RISE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (st == S_WAIT || (st == S_HIGH && bitc == 4'd8))); // R6
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH) |-> $stable(sda_oe)); // R7
  AST_STOP_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && stop_pend) |=> (st == S_STOP1)); // R8
  AST_BUSY_FALL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!scl_oe && !sda_oe)); // R9
endmodule

// File: tb/i2c_rx_master_tb_top.sv
module i2c_rx_master_tb_top;
  localparam int HALF = 8;
  localparam logic [4:0] F_IRQ = 5'd1, F_ACK = 5'd2, F_WAIT = 5'd4, F_DIR = 5'd8, F_BUSY = 5'd16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 1'b0, dat_rd = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic [4:0] ctl_rdata;
  logic [7:0] rx_data;
  logic scl_oe, sda_oe, sda_in;

  logic [7:0] slv_byte = 8'hFF;
  int   slv_idx = 0;
  logic slv_rst = 1'b0;
  logic scl_prev = 1'b1;
  int   n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  i2c_rx_master #(.HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .dat_rd(dat_rd), .rx_data(rx_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in));

  assign sda_in = sda_oe ? 1'b0 : (slv_idx < 8 ? slv_byte[3'(7 - slv_idx)] : 1'b1);

  always @(posedge clk) begin
    if (slv_rst) slv_idx <= 0;
    else if (scl_prev && scl_oe) slv_idx <= slv_idx + 1;
    scl_prev <= !scl_oe;
  end

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [4:0] v);
    ctl_wdata = v; ctl_wr = 1'b1; tick; ctl_wr = 1'b0;
  endtask

  task automatic rd; dat_rd = 1'b1; tick; dat_rd = 1'b0; endtask

  task automatic load_slave(input logic [7:0] b);
    slv_byte = b; slv_rst = 1'b1; tick; tick; slv_rst = 1'b0;
  endtask

  task automatic wait_flag;
    for (int i = 0; i < 2000 && !ctl_rdata[0]; i++) tick;
  endtask

  task automatic wait_scl_low;
    for (int i = 0; i < 2000 && !scl_oe; i++) tick;
  endtask

  task automatic t_reset;
    chk(ctl_rdata == 5'd0, "R1 ctl", ctl_rdata, 0);
    chk(rx_data == 8'd0, "R1 data", rx_data, 0);
    chk(!scl_oe && !sda_oe, "R1 pads", {scl_oe, sda_oe}, 0);
    rd;
    for (int i = 0; i < 20; i++) tick;
    chk(!scl_oe, "R2 read while free ignored", scl_oe, 0);
    ctl(F_BUSY);
    tick;
    chk(ctl_rdata[4] && scl_oe, "R2 claim", {ctl_rdata[4], scl_oe}, 3);
  endtask

  task automatic t_nowait_byte;
    int n, m;
    load_slave(8'hA5);
    rd; n = 1;
    for (int i = 0; i < 2000 && scl_oe; i++) begin tick; n++; end
    chk(n == HALF + 2, "R2 first rise latency", n, HALF + 2);
    m = 0;
    for (int i = 0; i < 2000 && !scl_oe; i++) begin tick; m++; end
    chk(m == HALF, "R12 high phase", m, HALF);
    wait_flag;
    chk(!scl_oe, "R6 flag at ninth rise", scl_oe, 0);
    chk(sda_oe, "R7 ack pulls SDA", sda_oe, 1);
    chk(rx_data == 8'hA5, "R3 data", rx_data, 8'hA5);
    wait_scl_low; tick;
    chk(!sda_oe, "R7 SDA released after ack", sda_oe, 0);
  endtask

  task automatic t_wait_byte;
    int held, n;
    ctl(F_BUSY | F_WAIT);
    chk(!ctl_rdata[0], "R11 write 0 clears", ctl_rdata[0], 0);
    load_slave(8'h3C);
    rd;
    wait_flag;
    chk(scl_oe, "R4 SCL held at flag", scl_oe, 1);
    chk(rx_data == 8'h3C, "R3 R8 next byte data", rx_data, 8'h3C);
    held = 0;
    for (int i = 0; i < 40; i++) begin tick; if (scl_oe) held++; end
    chk(held == 40, "R4 hold while flag", held, 40);
    ctl(F_BUSY | F_WAIT | F_IRQ);
    chk(ctl_rdata[0] && scl_oe, "R11 write 1 ignored", {ctl_rdata[0], scl_oe}, 3);
    ctl(F_BUSY | F_WAIT); n = 1;
    for (int i = 0; i < 2000 && scl_oe; i++) begin tick; n++; end
    chk(n == HALF + 2, "R5 ninth rise latency", n, HALF + 2);
    chk(sda_oe, "R7 ack in wait mode", sda_oe, 1);
    chk(!ctl_rdata[0], "R4 no flag at ninth rise", ctl_rdata[0], 0);
    wait_scl_low;
  endtask

  task automatic t_busy_ignored;
    int held;
    ctl(5'd0);
    held = 0;
    for (int i = 0; i < 20; i++) begin tick; if (scl_oe && !sda_oe) held++; end
    chk(ctl_rdata[4] == 1'b1, "R10 busy kept", ctl_rdata[4], 1);
    chk(held == 20, "R10 bus still held", held, 20);
  endtask

  task automatic t_final_stop;
    int rises, stop_pat, i;
    ctl(F_BUSY | F_ACK);
    load_slave(8'h5A);
    rd;
    wait_flag;
    chk(!scl_oe && !sda_oe, "R7 nack releases SDA", {scl_oe, sda_oe}, 0);
    chk(rx_data == 8'h5A, "R3 final data", rx_data, 8'h5A);
    ctl(F_BUSY | F_ACK | F_DIR);
    ctl(F_ACK | F_DIR);
    rd;
    wait_scl_low;
    rises = 0; stop_pat = 0;
    for (i = 0; i < 2000 && ctl_rdata[4]; i++) begin
      tick;
      if (!scl_oe && scl_prev == 1'b0) rises++;
      if (!scl_oe && sda_oe) stop_pat++;
      if (!scl_oe && sda_oe && rises == 0) rises = rises;
    end
    chk(rises == 1, "R9 R8 single stop rise", rises, 1);
    chk(stop_pat > 0, "R9 SDA low with SCL high", stop_pat, 1);
    chk(!ctl_rdata[4] && !scl_oe && !sda_oe, "R9 bus freed",
        {ctl_rdata[4], scl_oe, sda_oe}, 0);
    chk(rx_data == 8'h5A, "R8 no byte after stop", rx_data, 8'h5A);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick; tick;
    rst_n = 1'b1;
    tick;
    t_reset;
    t_nowait_byte;
    t_wait_byte;
    t_busy_ignored;
    t_final_stop;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule